// File: doc/BRIEF.md
# Two-Channel Sequential Break Controller

This block is a debug break unit that sits beside a processor's retire stage. Each cycle it may see one instruction presented for execution. The presentation carries the instruction's address, whether the instruction has a delay slot, the branch outcome and target, and an optional operand access with its address and data. Two comparator channels, A and B, can each watch either the instruction address or the operand access. An operand condition compares the address alone or the address together with the data. Per-bit masks widen each compare.

When a condition is met, the block raises a break request and presents the program counter value that the exception logic must save. The request is held until it is acknowledged. How far the break lands from the matching instruction depends on the condition type. A fetch match stops the matching instruction itself. An operand-address match stops the instruction after it. An address-plus-data match stops a fixed number of instructions later. A break never falls between a branch and its delay slot. A sequential mode makes channel B break only after channel A has matched earlier, with a minimum spacing between the two. The block also gates an asynchronous interrupt line, so that a break that is due or pending always wins over the interrupt.

Top module: `dbg_break_ctl`

## Requirements
- R1: With a channel of kind 1 (fetch address), an instruction whose address matches raises `brk_req_o` at the next clock edge, and `brk_pc_o` is that instruction's own address.
- R2: A bit set in a channel's address mask is left out of the address compare. A bit set in its data mask is left out of the data compare.
- R3: With kind 2 (operand address), a matching operand access raises the request after that instruction, and the saved PC is the next instruction's address (instruction address + INSN_BYTES).
- R4: With kind 3 (operand address and data), a match on instruction M lets M+1 … M+DATA_LAT-1 complete and raises the request after M+DATA_LAT-1. The saved PC is the address of M+DATA_LAT. A data mismatch gives no break.
- R5: If the break point falls just after a branch that has a delay slot, the break waits until the slot instruction completes. The saved PC is then the branch target if the branch was taken, and otherwise the slot address + INSN_BYTES. The same holds when the slot instruction is the one that matches.
- R6: With `seq_en_i` high, channel A never breaks by itself, and a B match with no earlier A match gives no break. A B match two or more instructions after an A match breaks, using B's own kind.
- R7: In sequential mode, a B match on the same instruction as the A match, or on the instruction right after it, gives no break. The A match stays recorded, so a later B match two or more instructions after A still breaks.
- R8: The recorded A match is kept across any number of instructions. It is cleared when a sequential break condition is met and on any channel configuration write.
- R9: `brk_req_o` and `brk_pc_o` hold until `brk_ack_i` is high at a clock edge. Conditions met while a request is pending are ignored and do not cause a later break.
- R10: `irq_take_o` follows `irq_i`, except that it is low while a request is pending, while a delayed break is counting down, and in the cycle a break is detected.
- R11: A channel of kind 0 (off) never matches. Channel select 0 writes channel A and 1 writes channel B.
- R12: When operand conditions of both kinds match on one instruction, the earlier break point is used. A fetch match on an instruction stops that instruction even when a delayed operand break would have fired after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Channel configuration write strobe |
| cfg_sel_i | input | 1 | Channel written: 0 = A, 1 = B |
| cfg_kind_i | input | 2 | Condition kind: 0 off, 1 fetch address, 2 operand address, 3 operand address and data |
| cfg_addr_i | input | AW | Compare address |
| cfg_amask_i | input | AW | Address mask, 1 = bit ignored |
| cfg_data_i | input | DW | Compare data |
| cfg_dmask_i | input | DW | Data mask, 1 = bit ignored |
| seq_en_i | input | 1 | Sequential mode (A then B) |
| ret_valid_i | input | 1 | An instruction is presented this cycle |
| ret_pc_i | input | AW | Address of the presented instruction |
| ret_branch_i | input | 1 | Instruction is a branch with a delay slot |
| ret_taken_i | input | 1 | Branch outcome |
| ret_target_i | input | AW | Branch target |
| ret_op_valid_i | input | 1 | Instruction performs an operand access |
| ret_op_addr_i | input | AW | Operand address |
| ret_op_data_i | input | DW | Operand data |
| irq_i | input | 1 | Asynchronous interrupt request |
| brk_ack_i | input | 1 | Acknowledge of the break request |
| brk_req_o | output | 1 | Break request, held until acknowledged |
| brk_pc_o | output | AW | PC value to save for the break |
| irq_take_o | output | 1 | Interrupt allowed through this cycle |

## Verification
The bench runs B-after-A spacings from zero to three instructions. Too loose a spacing check would break at distance zero or one. Too strict a check, or one that forgets the A match, would miss the later B at distance two or three. Each delayed break is counted out one instruction at a time. A countdown that is off by one shows up as a request one instruction early or late, with a saved PC that is off by INSN_BYTES. A break landing on a branch is run with the branch taken and with it not taken, and with the slot as the matching instruction. A design that ignores the delay slot would stop at the slot or save the fall-through address instead of the target. The masks are swept across neighbouring addresses. A sweep of this kind catches an inverted mask, and catches a match that still fires while a request is pending or once the A record has been cleared.

// File: rtl/dbg_break_pkg.sv
package dbg_break_pkg;

   typedef enum logic [1:0] {
      KIND_OFF    = 2'd0,
      KIND_FETCH  = 2'd1,
      KIND_OPADDR = 2'd2,
      KIND_OPDATA = 2'd3
   } brk_kind_e;

   // per-channel compare results for one presented instruction
   typedef struct packed {
      logic fetch;
      logic op_addr;
      logic op_data;
   } brk_hit_t;

endpackage

// File: rtl/dbg_break_chan.sv
module dbg_break_chan
   import dbg_break_pkg::*;
#(
   parameter int AW = 32,
   parameter int DW = 32
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          we_i,
   input  logic [1:0]    kind_i,
   input  logic [AW-1:0] addr_i,
   input  logic [AW-1:0] amask_i,
   input  logic [DW-1:0] data_i,
   input  logic [DW-1:0] dmask_i,
   input  logic [AW-1:0] pc_i,
   input  logic          op_valid_i,
   input  logic [AW-1:0] op_addr_i,
   input  logic [DW-1:0] op_data_i,
   output brk_hit_t      hit_o
);

   brk_kind_e     kind_q;
   logic [AW-1:0] addr_q, amask_q;
   logic [DW-1:0] data_q, dmask_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         kind_q  <= KIND_OFF;
         addr_q  <= '0;
         amask_q <= '0;
         data_q  <= '0;
         dmask_q <= '0;
      end else if (we_i) begin
         kind_q  <= brk_kind_e'(kind_i);
         addr_q  <= addr_i;
         amask_q <= amask_i;
         data_q  <= data_i;
         dmask_q <= dmask_i;
      end
   end

   logic pc_eq, op_eq, data_eq;

   always_comb begin
      pc_eq   = ((pc_i      ^ addr_q) & ~amask_q) == '0;
      op_eq   = ((op_addr_i ^ addr_q) & ~amask_q) == '0;
      data_eq = ((op_data_i ^ data_q) & ~dmask_q) == '0;
      hit_o.fetch   = (kind_q == KIND_FETCH)  && pc_eq;
      hit_o.op_addr = (kind_q == KIND_OPADDR) && op_valid_i && op_eq;
      hit_o.op_data = (kind_q == KIND_OPDATA) && op_valid_i && op_eq && data_eq;
   end

endmodule

// File: rtl/dbg_break_seq.sv
module dbg_break_seq (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic en_i,
   input  logic clr_i,
   input  logic act_i,
   input  logic a_hit_i,
   input  logic take_i,
   output logic ready_o
);

   // 0: no A match, 1: A matched on the last instruction, 2: two or more ago
   logic [1:0] dist_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         dist_q <= 2'd0;
      end else if (!en_i || clr_i || take_i) begin
         dist_q <= 2'd0;
      end else if (act_i) begin
         if (dist_q == 2'd0 && a_hit_i) dist_q <= 2'd1;
         else if (dist_q == 2'd1)       dist_q <= 2'd2;
      end
   end

   assign ready_o = (dist_q == 2'd2);

   // no jump from "no A seen" straight to "ready": spacing of at least two (R7)
   p_spacing_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dist_q == 2'd0) |=> (dist_q != 2'd2));

   // once ready, the A record holds until consumed or cleared (R8)
   p_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dist_q == 2'd2 && en_i && !clr_i && !take_i) |=> (dist_q == 2'd2));

endmodule

// File: rtl/dbg_break_delay.sv
module dbg_break_delay #(
   parameter int AW  = 32,
   parameter int LAT = 2,
   parameter int IB  = 2
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          act_i,
   input  logic          kill_i,
   input  logic          oa_i,
   input  logic          od_i,
   input  logic          br_i,
   input  logic          tk_i,
   input  logic [AW-1:0] tgt_i,
   input  logic [AW-1:0] pc_i,
   output logic          fire_o,
   output logic [AW-1:0] fire_pc_o,
   output logic          armed_o
);

   localparam int RW = 2;
   localparam logic [RW-1:0] DATA_REM = RW'(LAT - 1);

   if (LAT < 1 || LAT > 4) begin : g_lat_chk
      $error("dbg_break_delay: LAT must lie in 1..4");
   end

   logic          armed_q;
   logic [RW-1:0] rem_q;
   logic          slot_q, slot_tk_q;
   logic [AW-1:0] slot_tgt_q;

   logic          new_hit, eff_valid;
   logic [RW-1:0] old_rem, new_rem, eff_rem;

   always_comb begin
      fire_pc_o = (slot_q && slot_tk_q) ? slot_tgt_q : pc_i + AW'(IB);
      old_rem   = (rem_q == '0) ? '0 : rem_q - 1'b1;
      new_hit   = oa_i || od_i;
      new_rem   = oa_i ? '0 : DATA_REM;
      eff_valid = armed_q || new_hit;
      if (armed_q && (!new_hit || old_rem < new_rem)) eff_rem = old_rem;
      else                                            eff_rem = new_rem;
      fire_o    = act_i && eff_valid && (eff_rem == '0) && !br_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         armed_q    <= 1'b0;
         rem_q      <= '0;
         slot_q     <= 1'b0;
         slot_tk_q  <= 1'b0;
         slot_tgt_q <= '0;
      end else if (kill_i) begin
         armed_q <= 1'b0;
         slot_q  <= 1'b0;
      end else if (act_i) begin
         armed_q    <= eff_valid && !fire_o;
         rem_q      <= eff_rem;
         slot_q     <= br_i;
         slot_tk_q  <= tk_i;
         slot_tgt_q <= tgt_i;
      end
   end

   assign armed_o = armed_q;

   // countdown never exceeds the configured latency (R4)
   p_rem_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      armed_q |-> (rem_q <= DATA_REM));

   // a due break at a branch is carried over into the delay slot (R5)
   p_slot_carry_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (act_i && !kill_i && br_i && (armed_q || new_hit)) |=> armed_q);

endmodule

// File: rtl/dbg_break_ctl.sv
module dbg_break_ctl
   import dbg_break_pkg::*;
#(
   parameter int AW         = 32,
   parameter int DW         = 32,
   parameter int DATA_LAT   = 2,
   parameter int INSN_BYTES = 2
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          cfg_we_i,
   input  logic          cfg_sel_i,
   input  logic [1:0]    cfg_kind_i,
   input  logic [AW-1:0] cfg_addr_i,
   input  logic [AW-1:0] cfg_amask_i,
   input  logic [DW-1:0] cfg_data_i,
   input  logic [DW-1:0] cfg_dmask_i,
   input  logic          seq_en_i,
   input  logic          ret_valid_i,
   input  logic [AW-1:0] ret_pc_i,
   input  logic          ret_branch_i,
   input  logic          ret_taken_i,
   input  logic [AW-1:0] ret_target_i,
   input  logic          ret_op_valid_i,
   input  logic [AW-1:0] ret_op_addr_i,
   input  logic [DW-1:0] ret_op_data_i,
   input  logic          irq_i,
   input  logic          brk_ack_i,
   output logic          brk_req_o,
   output logic [AW-1:0] brk_pc_o,
   output logic          irq_take_o
);

   localparam int NCH = 2;
   localparam int CH_A = 0;
   localparam int CH_B = 1;

   if (AW < 2 || DW < 1) begin : g_width_chk
      $error("dbg_break_ctl: AW must be at least 2 and DW at least 1");
   end
   if (INSN_BYTES < 1 || (INSN_BYTES & (INSN_BYTES - 1)) != 0) begin : g_ib_chk
      $error("dbg_break_ctl: INSN_BYTES must be a power of two");
   end

   brk_hit_t hit [NCH];

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      dbg_break_chan #(.AW(AW), .DW(DW)) u_chan (
         .clk_i      (clk_i),
         .rst_ni     (rst_ni),
         .we_i       (cfg_we_i && (cfg_sel_i == 1'(c))),
         .kind_i     (cfg_kind_i),
         .addr_i     (cfg_addr_i),
         .amask_i    (cfg_amask_i),
         .data_i     (cfg_data_i),
         .dmask_i    (cfg_dmask_i),
         .pc_i       (ret_pc_i),
         .op_valid_i (ret_op_valid_i),
         .op_addr_i  (ret_op_addr_i),
         .op_data_i  (ret_op_data_i),
         .hit_o      (hit[c])
      );
   end

   logic          req_q;
   logic [AW-1:0] pc_q;
   logic          act, a_any, b_any, seq_ready, en_a, en_b, seq_take;
   logic          fetch_hit, oa_hit, od_hit, op_fire, fire_any, armed;
   logic [AW-1:0] op_pc;

   always_comb begin
      act       = ret_valid_i && !req_q;
      a_any     = hit[CH_A].fetch || hit[CH_A].op_addr || hit[CH_A].op_data;
      b_any     = hit[CH_B].fetch || hit[CH_B].op_addr || hit[CH_B].op_data;
      en_a      = !seq_en_i;
      en_b      = !seq_en_i || seq_ready;
      seq_take  = act && seq_en_i && seq_ready && b_any;
      fetch_hit = act && ((en_a && hit[CH_A].fetch) || (en_b && hit[CH_B].fetch));
      oa_hit    = act && !fetch_hit &&
                  ((en_a && hit[CH_A].op_addr) || (en_b && hit[CH_B].op_addr));
      od_hit    = act && !fetch_hit &&
                  ((en_a && hit[CH_A].op_data) || (en_b && hit[CH_B].op_data));
   end

   dbg_break_seq u_seq (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (seq_en_i),
      .clr_i   (cfg_we_i),
      .act_i   (act),
      .a_hit_i (a_any),
      .take_i  (seq_take),
      .ready_o (seq_ready)
   );

   dbg_break_delay #(.AW(AW), .LAT(DATA_LAT), .IB(INSN_BYTES)) u_delay (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .act_i     (act && !fetch_hit),
      .kill_i    (fetch_hit),
      .oa_i      (oa_hit),
      .od_i      (od_hit),
      .br_i      (ret_branch_i),
      .tk_i      (ret_taken_i),
      .tgt_i     (ret_target_i),
      .pc_i      (ret_pc_i),
      .fire_o    (op_fire),
      .fire_pc_o (op_pc),
      .armed_o   (armed)
   );

   assign fire_any = fetch_hit || op_fire;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         req_q <= 1'b0;
         pc_q  <= '0;
      end else if (fire_any) begin
         req_q <= 1'b1;
         pc_q  <= fetch_hit ? ret_pc_i : op_pc;
      end else if (brk_ack_i) begin
         req_q <= 1'b0;
      end
   end

   assign brk_req_o  = req_q;
   assign brk_pc_o   = pc_q;
   assign irq_take_o = irq_i && !req_q && !armed && !fire_any;

   // pending request and its PC hold until acknowledged (R9)
   p_req_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_q && !brk_ack_i) |=> (req_q && $stable(brk_pc_o)));

   // acknowledge drops the request (R9)
   p_ack_drop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_q && brk_ack_i) |=> !req_q);

   // nothing counts down while a request is outstanding (R9)
   p_quiet_pending_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_q |-> !armed);

   // interrupt is held off by a pending or counting break (R10)
   p_irq_gate_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_q || armed) |-> !irq_take_o);

   // a fetch break saves the address of the instruction it stopped (R1)
   p_fetch_pc_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fetch_hit |=> (brk_req_o && brk_pc_o == $past(ret_pc_i)));

endmodule

// File: tb/dbg_break_ctl_tb_top.sv
`timescale 1ns/1ps
module dbg_break_ctl_tb_top;

   localparam int AW = 16;
   localparam int DW = 16;
   localparam int LAT = 3;
   localparam int IB = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0, cfg_sel = 1'b0;
   logic [1:0]    cfg_kind = 2'd0;
   logic [AW-1:0] cfg_addr = '0, cfg_amask = '0;
   logic [DW-1:0] cfg_data = '0, cfg_dmask = '0;
   logic          seq_en = 1'b0;
   logic          rv = 1'b0, rbr = 1'b0, rtk = 1'b0, rop = 1'b0;
   logic [AW-1:0] rpc = '0, rtgt = '0, roa = '0;
   logic [DW-1:0] rod = '0;
   logic          irq = 1'b0, ack = 1'b0;
   logic          req, irq_take, mid_irq;
   logic [AW-1:0] bpc;

   int total = 0;
   int bad = 0;

   always #4 clk = ~clk;

   dbg_break_ctl #(.AW(AW), .DW(DW), .DATA_LAT(LAT), .INSN_BYTES(IB)) dut_i (
      .clk_i(clk), .rst_ni(rst_n),
      .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_kind_i(cfg_kind),
      .cfg_addr_i(cfg_addr), .cfg_amask_i(cfg_amask),
      .cfg_data_i(cfg_data), .cfg_dmask_i(cfg_dmask),
      .seq_en_i(seq_en),
      .ret_valid_i(rv), .ret_pc_i(rpc), .ret_branch_i(rbr), .ret_taken_i(rtk),
      .ret_target_i(rtgt), .ret_op_valid_i(rop), .ret_op_addr_i(roa),
      .ret_op_data_i(rod),
      .irq_i(irq), .brk_ack_i(ack),
      .brk_req_o(req), .brk_pc_o(bpc), .irq_take_o(irq_take)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic chk_brk(input string tag, input logic er, input logic [AW-1:0] ep);
      chk(tag, 32'(req), 32'(er));
      if (er) chk({tag, " pc"}, 32'(bpc), 32'(ep));
   endtask

   task automatic cfg(input logic sel, input logic [1:0] kind, input logic [AW-1:0] a,
                      input logic [AW-1:0] am, input logic [DW-1:0] d, input logic [DW-1:0] dm);
      cfg_we = 1'b1; cfg_sel = sel; cfg_kind = kind;
      cfg_addr = a; cfg_amask = am; cfg_data = d; cfg_dmask = dm;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic ins(input logic [AW-1:0] pc, input logic br, input logic tk,
                      input logic [AW-1:0] tgt, input logic opv,
                      input logic [AW-1:0] oa, input logic [DW-1:0] od);
      rv = 1'b1; rpc = pc; rbr = br; rtk = tk; rtgt = tgt;
      rop = opv; roa = oa; rod = od;
      #1 mid_irq = irq_take;
      @(negedge clk);
      rv = 1'b0; rbr = 1'b0; rop = 1'b0;
   endtask

   task automatic plain(input logic [AW-1:0] pc);
      ins(pc, 1'b0, 1'b0, '0, 1'b0, '0, '0);
   endtask

   task automatic opi(input logic [AW-1:0] pc, input logic [AW-1:0] oa, input logic [DW-1:0] od);
      ins(pc, 1'b0, 1'b0, '0, 1'b1, oa, od);
   endtask

   task automatic do_ack();
      ack = 1'b1;
      @(negedge clk);
      ack = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      irq = 1'b1;
      #1;
      chk("R9 reset req", 32'(req), 0);
      chk("R10 reset irq pass", 32'(irq_take), 1);
      irq = 1'b0;
      @(negedge clk);

      // R11: channels off never break
      for (int i = 0; i < 4; i++) begin
         opi(16'h0100 + 16'(2 * i), 16'h0000, 16'h0000);
         chk_brk("R11 off", 1'b0, '0);
      end

      // R1: fetch address break
      cfg(1'b0, 2'd1, 16'h0120, '0, '0, '0);
      for (int i = 0; i < 4; i++) begin
         logic [AW-1:0] p;
         p = 16'h011A + 16'(2 * i);
         plain(p);
         chk_brk("R1 fetch", p == 16'h0120, p);
      end
      do_ack();
      chk_brk("R9 ack clears", 1'b0, '0);

      // R2: address mask sweep on fetch
      cfg(1'b0, 2'd1, 16'h0200, 16'h000C, '0, '0);
      for (int i = 0; i < 9; i++) begin
         logic [AW-1:0] p;
         p = 16'h0200 + 16'(2 * i);
         plain(p);
         chk_brk("R2 addr mask", ((p ^ 16'h0200) & ~16'h000C) == '0, p);
         if (req) do_ack();
      end

      // R3 + R10: operand address only
      cfg(1'b0, 2'd2, 16'h0040, '0, '0, '0);
      irq = 1'b1;
      opi(16'h0300, 16'h0010, '0);
      chk("R10 irq pass idle", 32'(mid_irq), 1);
      chk_brk("R3 no match", 1'b0, '0);
      opi(16'h0302, 16'h0040, '0);
      chk("R10 irq blocked at fire", 32'(mid_irq), 0);
      chk_brk("R3 op addr", 1'b1, 16'h0304);
      do_ack();

      // R4: address+data, fixed latency
      cfg(1'b0, 2'd3, 16'h0050, '0, 16'h00AB, '0);
      opi(16'h0400, 16'h0050, 16'h00AB);
      chk_brk("R4 lat m0", 1'b0, '0);
      chk("R10 irq blocked while armed", 32'(irq_take), 0);
      plain(16'h0402);
      chk_brk("R4 lat m1", 1'b0, '0);
      plain(16'h0404);
      chk_brk("R4 lat m2", 1'b1, 16'h0400 + 16'(IB * LAT));
      chk("R10 irq blocked pending", 32'(irq_take), 0);
      // R9: match while pending is ignored, request holds
      opi(16'h0408, 16'h0050, 16'h00AB);
      chk_brk("R9 hold", 1'b1, 16'h0406);
      plain(16'h040A);
      chk_brk("R9 hold2", 1'b1, 16'h0406);
      do_ack();
      chk("R10 irq pass after ack", 32'(irq_take), 1);
      for (int i = 0; i < 4; i++) begin
         plain(16'h0410 + 16'(2 * i));
         chk_brk("R9 ignored match", 1'b0, '0);
      end
      irq = 1'b0;
      // R4: data mismatch
      opi(16'h0420, 16'h0050, 16'h00AC);
      for (int i = 0; i < 4; i++) plain(16'h0422 + 16'(2 * i));
      chk_brk("R4 data mismatch", 1'b0, '0);
      // R2: data mask
      cfg(1'b0, 2'd3, 16'h0050, '0, 16'h00AB, 16'h0001);
      opi(16'h0440, 16'h0050, 16'h00AA);
      plain(16'h0442);
      plain(16'h0444);
      chk_brk("R2 data mask", 1'b1, 16'h0446);
      do_ack();

      // R5: break point at a branch, both outcomes
      for (int tk = 0; tk < 2; tk++) begin
         cfg(1'b0, 2'd2, 16'h0060, '0, '0, '0);
         ins(16'h0500, 1'b1, 1'(tk), 16'h0600, 1'b1, 16'h0060, '0);
         chk_brk("R5 at branch", 1'b0, '0);
         plain(16'h0502);
         chk_brk("R5 after slot", 1'b1, (tk != 0) ? 16'h0600 : 16'h0504);
         do_ack();
         ins(16'h0900, 1'b1, 1'(tk), 16'h0A00, 1'b0, '0, '0);
         opi(16'h0902, 16'h0060, '0);
         chk_brk("R5 slot match", 1'b1, (tk != 0) ? 16'h0A00 : 16'h0904);
         do_ack();
      end
      cfg(1'b0, 2'd3, 16'h0050, '0, 16'h00AB, '0);
      opi(16'h0700, 16'h0050, 16'h00AB);
      plain(16'h0702);
      ins(16'h0704, 1'b1, 1'b1, 16'h0800, 1'b0, '0, '0);
      chk_brk("R5 delayed at branch", 1'b0, '0);
      plain(16'h0706);
      chk_brk("R5 delayed slot", 1'b1, 16'h0800);
      do_ack();

      // R6/R7: sequential spacing sweep
      seq_en = 1'b1;
      cfg(1'b1, 2'd2, 16'h0080, '0, '0, '0);
      for (int d = 0; d < 4; d++) begin
         cfg(1'b0, 2'd1, 16'h0C10, '0, '0, '0);
         plain(16'h0BFE);
         ins(16'h0C10, 1'b0, 1'b0, '0, d == 0, 16'h0080, '0);
         for (int k = 1; k <= d; k++)
            ins(16'h0C10 + 16'(2 * k), 1'b0, 1'b0, '0, k == d, 16'h0080, '0);
         chk_brk("R7 spacing", d >= 2, 16'h0C12 + 16'(2 * d));
         if (d < 2) begin
            plain(16'h0C12 + 16'(2 * d));
            chk_brk("R7 no late break", 1'b0, '0);
         end
         if (d == 1) begin
            opi(16'h0C16, 16'h0080, '0);
            chk_brk("R7 record kept", 1'b1, 16'h0C18);
         end
         if (req) do_ack();
      end
      // R6: B alone, A alone
      cfg(1'b0, 2'd1, 16'h0C10, '0, '0, '0);
      opi(16'h0D00, 16'h0080, '0);
      chk_brk("R6 B alone", 1'b0, '0);
      plain(16'h0C10);
      for (int i = 0; i < 5; i++) plain(16'h0C12 + 16'(2 * i));
      chk_brk("R6 A alone", 1'b0, '0);
      // R8: sticky then cleared by the break
      opi(16'h0D02, 16'h0080, '0);
      chk_brk("R8 sticky", 1'b1, 16'h0D04);
      do_ack();
      opi(16'h0D06, 16'h0080, '0);
      chk_brk("R8 cleared by break", 1'b0, '0);
      // R8: cleared by configuration write
      plain(16'h0C10);
      plain(16'h0C12);
      plain(16'h0C14);
      cfg(1'b1, 2'd2, 16'h0080, '0, '0, '0);
      opi(16'h0C16, 16'h0080, '0);
      chk_brk("R8 cleared by write", 1'b0, '0);
      seq_en = 1'b0;

      // R12: both operand kinds on one instruction
      cfg(1'b0, 2'd2, 16'h0090, '0, '0, '0);
      cfg(1'b1, 2'd3, 16'h0090, '0, 16'h0033, '0);
      opi(16'h0E00, 16'h0090, 16'h0033);
      chk_brk("R12 earliest", 1'b1, 16'h0E02);
      do_ack();
      // R12: fetch stop beats pending operand break
      cfg(1'b0, 2'd3, 16'h0050, '0, 16'h00AB, '0);
      cfg(1'b1, 2'd1, 16'h0F04, '0, '0, '0);
      opi(16'h0F00, 16'h0050, 16'h00AB);
      plain(16'h0F02);
      chk_brk("R12 pre", 1'b0, '0);
      plain(16'h0F04);
      chk_brk("R12 fetch wins", 1'b1, 16'h0F04);
      do_ack();
      plain(16'h0F06);
      chk_brk("R12 no second", 1'b0, '0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule